// File: doc/BRIEF.md
# Snapshot-Fair Host Slot Transfer Scheduler

This block decides which host input slot the DMA engine moves next and which on-chip staging buffer receives it. The host input area is divided into equal slots, and software raises a per-slot full flag once a slot holds data. The block freezes a copy of those flags and works through every slot in that copy before it looks at the live flags again. A slot raised in the meantime therefore waits for the next round and cannot overtake slots that were already waiting. Each transfer lands in whichever of two ping-pong staging buffers is free. When the transfer completes, the block tells software to drop that slot's flag.

On the return path the block takes one result at a time. It writes the result into its host output slot only while that slot reads empty. When the write completes, it marks the slot full and raises an interrupt. The host transaction layer and the DMA datapath sit outside the block and are reached through plain request/done handshakes.

Top module: `hsd_slot_dma_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no transfer request, flag clear, result accept, output write or interrupt is active; both staging buffers start free, and the first transfer goes to buffer 0.
- R2: While the frozen copy is empty, the live flags (bit i belongs to slot i) are sampled every cycle. A flag that first appears at a clock edge gives a transfer request two edges later.
- R3: Within one frozen copy, slots are requested in ascending index order, from slot 0 up to the highest slot.
- R4: A flag raised after the copy was frozen is not served, even at a lower index, until every slot of the current copy has been served.
- R5: Each completed transfer (`dma_done_i` while `dma_req_o` is high) gives exactly one clear pulse in the same cycle, and the clear names the slot that was transferred.
- R6: Staging buffers are named 0 and 1 on `dma_buf_o`. A buffer is used only when free. The buffer after the last one used is preferred, the other one is taken if the preferred one is busy, and no request is made while both are busy. A buffer becomes busy when chosen and free after its release pulse.
- R7: A transfer request holds its slot and buffer unchanged until done, and drops in the cycle after done.
- R8: A result aimed at an output slot whose full flag is set is held, neither accepted nor written nor dropped, until that flag reads clear.
- R9: A completed output write gives a set pulse for `out_slot_o` in the done cycle and a one-cycle interrupt pulse in the following cycle.
- R10: A result is accepted only in the cycle its write starts; the write request follows in the next cycle and names the accepted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_full_i | input | NUM_SLOTS | Live input slot full flags, bit i for slot i |
| in_clr_valid_o | output | 1 | Pulse: software should clear the named input flag |
| in_clr_slot_o | output | SLOT_W | Input slot whose flag is to be cleared |
| dma_req_o | output | 1 | Inbound transfer request, held until done |
| dma_slot_o | output | SLOT_W | Input slot to transfer |
| dma_buf_o | output | 1 | Destination staging buffer (0 or 1) |
| dma_done_i | input | 1 | Inbound transfer complete |
| stg_release_i | input | 2 | Pulse per staging buffer: buffer drained and free |
| res_valid_i | input | 1 | A result is waiting |
| res_slot_i | input | SLOT_W | Output slot for the waiting result |
| res_ready_o | output | 1 | Result accepted this cycle |
| out_full_i | input | NUM_SLOTS | Live output slot full flags, bit i for slot i |
| out_req_o | output | 1 | Outbound write request, held until done |
| out_slot_o | output | SLOT_W | Output slot being written |
| out_done_i | input | 1 | Outbound write complete |
| out_set_valid_o | output | 1 | Pulse: mark `out_slot_o` full |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
A stale bit in the frozen copy shows at the ports as a repeated slot, or as a newly raised slot jumping ahead. Either appears at the first request after the wrong transfer completes. A staging busy bit that is stuck or cleared too early appears within a few cycles, as a request that never comes or as a buffer number that breaks the alternation the bench predicts. A wrong state in the output writer shows up as a write into a full slot, a lost result, or an interrupt that is missing or not exactly one cycle after the set pulse.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic {
        IN_SCAN = 1'b0,
        IN_XFER = 1'b1
    } in_state_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_WRITE = 1'b1
    } out_state_e;

endpackage

// File: rtl/hsd_lowest_pick.sv
module hsd_lowest_pick #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
        found_o = |vec_i;
    end

endmodule

// File: rtl/hsd_stage_alloc.sv
module hsd_stage_alloc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_i,
    input  logic       grant_sel_i,
    input  logic [1:0] release_i,
    output logic       avail_o,
    output logic       pick_o
);

    typedef struct packed {
        logic [1:0] busy;
        logic       pref;
    } alloc_regs_t;

    alloc_regs_t q, d;

    always_comb begin
        d      = q;
        d.busy = q.busy & ~release_i;
        if (grant_i) begin
            d.busy[grant_sel_i] = 1'b1;
            d.pref              = ~grant_sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        pick_o  = q.busy[q.pref] ? ~q.pref : q.pref;
        avail_o = ~&q.busy;
    end

endmodule

// File: rtl/hsd_in_sched.sv
module hsd_in_sched
    import hsd_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] in_full_i,
    input  logic                 dma_done_i,
    input  logic [1:0]           stg_release_i,
    output logic                 dma_req_o,
    output logic [SLOT_W-1:0]    dma_slot_o,
    output logic                 dma_buf_o,
    output logic                 in_clr_valid_o,
    output logic [SLOT_W-1:0]    in_clr_slot_o
);

    typedef struct packed {
        in_state_e            state;
        logic [NUM_SLOTS-1:0] snap;
        logic [SLOT_W-1:0]    slot;
        logic                 stg;
    } in_regs_t;

    in_regs_t q, d;

    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;
    logic              stg_avail;
    logic              stg_pick;
    logic              grant;

    hsd_lowest_pick #(.N(NUM_SLOTS)) i_pick (
        .vec_i   (q.snap),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    hsd_stage_alloc i_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant),
        .grant_sel_i (d.stg),
        .release_i   (stg_release_i),
        .avail_o     (stg_avail),
        .pick_o      (stg_pick)
    );

    always_comb begin
        d     = q;
        grant = 1'b0;
        unique case (q.state)
            IN_SCAN: begin
                if (!pick_found) begin
                    d.snap = in_full_i;
                end else if (stg_avail) begin
                    d.state = IN_XFER;
                    d.slot  = pick_idx;
                    d.stg   = stg_pick;
                    grant   = 1'b1;
                end
            end
            IN_XFER: begin
                if (dma_done_i) begin
                    d.state        = IN_SCAN;
                    d.snap[q.slot] = 1'b0;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dma_req_o      = (q.state == IN_XFER);
        dma_slot_o     = q.slot;
        dma_buf_o      = q.stg;
        in_clr_valid_o = (q.state == IN_XFER) && dma_done_i;
        in_clr_slot_o  = q.slot;
    end

endmodule

// File: rtl/hsd_out_writer.sv
module hsd_out_writer
    import hsd_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid_i,
    input  logic [SLOT_W-1:0]    res_slot_i,
    input  logic [NUM_SLOTS-1:0] out_full_i,
    input  logic                 out_done_i,
    output logic                 res_ready_o,
    output logic                 out_req_o,
    output logic [SLOT_W-1:0]    out_slot_o,
    output logic                 out_set_valid_o,
    output logic                 irq_o
);

    typedef struct packed {
        out_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic              irq;
    } out_regs_t;

    out_regs_t q, d;
    logic      accept;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        accept = 1'b0;
        unique case (q.state)
            OUT_IDLE: begin
                if (res_valid_i && !out_full_i[res_slot_i]) begin
                    accept  = 1'b1;
                    d.state = OUT_WRITE;
                    d.slot  = res_slot_i;
                end
            end
            OUT_WRITE: begin
                if (out_done_i) begin
                    d.state = OUT_IDLE;
                    d.irq   = 1'b1;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        res_ready_o     = accept;
        out_req_o       = (q.state == OUT_WRITE);
        out_slot_o      = q.slot;
        out_set_valid_o = (q.state == OUT_WRITE) && out_done_i;
        irq_o           = q.irq;
    end

endmodule

// File: rtl/hsd_slot_dma_sched.sv
module hsd_slot_dma_sched #(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] in_full_i,
    output logic                 in_clr_valid_o,
    output logic [SLOT_W-1:0]    in_clr_slot_o,
    output logic                 dma_req_o,
    output logic [SLOT_W-1:0]    dma_slot_o,
    output logic                 dma_buf_o,
    input  logic                 dma_done_i,
    input  logic [1:0]           stg_release_i,
    input  logic                 res_valid_i,
    input  logic [SLOT_W-1:0]    res_slot_i,
    output logic                 res_ready_o,
    input  logic [NUM_SLOTS-1:0] out_full_i,
    output logic                 out_req_o,
    output logic [SLOT_W-1:0]    out_slot_o,
    input  logic                 out_done_i,
    output logic                 out_set_valid_o,
    output logic                 irq_o
);

    hsd_in_sched #(.NUM_SLOTS(NUM_SLOTS)) i_in_sched (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_full_i      (in_full_i),
        .dma_done_i     (dma_done_i),
        .stg_release_i  (stg_release_i),
        .dma_req_o      (dma_req_o),
        .dma_slot_o     (dma_slot_o),
        .dma_buf_o      (dma_buf_o),
        .in_clr_valid_o (in_clr_valid_o),
        .in_clr_slot_o  (in_clr_slot_o)
    );

    hsd_out_writer #(.NUM_SLOTS(NUM_SLOTS)) i_out_writer (
        .clk             (clk),
        .rst_n           (rst_n),
        .res_valid_i     (res_valid_i),
        .res_slot_i      (res_slot_i),
        .out_full_i      (out_full_i),
        .out_done_i      (out_done_i),
        .res_ready_o     (res_ready_o),
        .out_req_o       (out_req_o),
        .out_slot_o      (out_slot_o),
        .out_set_valid_o (out_set_valid_o),
        .irq_o           (irq_o)
    );

endmodule

// File: rtl/hsd_sched_chk.sv
module hsd_sched_chk #(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dma_req_o,
    input logic [SLOT_W-1:0]    dma_slot_o,
    input logic                 dma_buf_o,
    input logic                 dma_done_i,
    input logic [1:0]           stg_release_i,
    input logic [SLOT_W-1:0]    res_slot_i,
    input logic                 res_ready_o,
    input logic [NUM_SLOTS-1:0] out_full_i,
    input logic                 out_req_o,
    input logic [SLOT_W-1:0]    out_slot_o,
    input logic                 out_done_i,
    input logic                 irq_o
);

    logic [1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= 2'b00;
        end else begin
            occ_q <= (occ_q & ~stg_release_i)
                   | ((dma_req_o && dma_done_i) ? (2'b01 << dma_buf_o) : 2'b00);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o && !dma_done_i |=> dma_req_o && $stable(dma_slot_o) && $stable(dma_buf_o)); // R7

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o && dma_done_i |=> !dma_req_o); // R7

    AST_BUF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_o) |-> !occ_q[dma_buf_o]); // R6

    AST_OUT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req_o) |-> !out_full_i[out_slot_o]); // R8

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        res_ready_o |=> out_req_o && (out_slot_o == $past(res_slot_i))); // R10

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_o && out_done_i |=> irq_o); // R9

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R9

endmodule

bind hsd_slot_dma_sched hsd_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) i_hsd_sched_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_req_o     (dma_req_o),
    .dma_slot_o    (dma_slot_o),
    .dma_buf_o     (dma_buf_o),
    .dma_done_i    (dma_done_i),
    .stg_release_i (stg_release_i),
    .res_slot_i    (res_slot_i),
    .res_ready_o   (res_ready_o),
    .out_full_i    (out_full_i),
    .out_req_o     (out_req_o),
    .out_slot_o    (out_slot_o),
    .out_done_i    (out_done_i),
    .irq_o         (irq_o)
);

// File: tb/test_hsd_slot_dma_sched.sv
module test_hsd_slot_dma_sched;

    localparam int NS = 64;
    localparam int SW = $clog2(NS);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [NS-1:0] in_flags, out_flags, sw_set, sw_out_clr;
    logic          in_clr_valid, dma_req, dma_buf, dma_done;
    logic [SW-1:0] in_clr_slot, dma_slot, res_slot, out_slot;
    logic [1:0]    man_rel, auto_pulse, stg_release;
    logic          res_valid, res_ready, out_req, out_done, out_set_valid, irq;
    logic          auto_rel;

    assign stg_release = man_rel | auto_pulse;

    hsd_slot_dma_sched #(.NUM_SLOTS(NS)) i_hsd_slot_dma_sched (
        .clk(clk), .rst_n(rst_n), .in_full_i(in_flags),
        .in_clr_valid_o(in_clr_valid), .in_clr_slot_o(in_clr_slot),
        .dma_req_o(dma_req), .dma_slot_o(dma_slot), .dma_buf_o(dma_buf),
        .dma_done_i(dma_done), .stg_release_i(stg_release),
        .res_valid_i(res_valid), .res_slot_i(res_slot), .res_ready_o(res_ready),
        .out_full_i(out_flags), .out_req_o(out_req), .out_slot_o(out_slot),
        .out_done_i(out_done), .out_set_valid_o(out_set_valid), .irq_o(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int exp_slot_q[$];
    int exp_buf_q[$];
    int exp_out_q[$];
    int in_done_cnt  = 0;
    int out_done_cnt = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // software flag models
    initial begin
        in_flags  = '0;
        out_flags = '0;
        forever begin
            @(posedge clk);
            in_flags  <= (in_flags & ~(in_clr_valid ? (NS'(1) << in_clr_slot) : NS'(0))) | sw_set;
            out_flags <= (out_flags | (out_set_valid ? (NS'(1) << out_slot) : NS'(0))) & ~sw_out_clr;
        end
    end

    // inbound DMA responder with optional automatic buffer release
    initial begin
        int dcnt;
        int rel_cnt [2];
        dcnt = 0; rel_cnt[0] = 0; rel_cnt[1] = 0;
        dma_done = 1'b0; auto_pulse = 2'b00;
        forever begin
            @(posedge clk); #1;
            auto_pulse = 2'b00;
            for (int b = 0; b < 2; b++) begin
                if (rel_cnt[b] > 0) begin
                    rel_cnt[b]--;
                    if (rel_cnt[b] == 0) auto_pulse[b] = 1'b1;
                end
            end
            if (dma_done) begin
                dma_done = 1'b0;
            end else if (dma_req) begin
                dcnt++;
                if (dcnt >= 2) begin
                    dma_done = 1'b1;
                    dcnt     = 0;
                    if (auto_rel) rel_cnt[dma_buf] = 2;
                end
            end
        end
    end

    // outbound write responder
    initial begin
        int ocnt;
        ocnt = 0;
        out_done = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (out_done) begin
                out_done = 1'b0;
            end else if (out_req) begin
                ocnt++;
                if (ocnt >= 2) begin
                    out_done = 1'b1;
                    ocnt     = 0;
                end
            end
        end
    end

    // monitor: scoreboard compare
    initial begin
        logic irq_exp;
        irq_exp = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dma_req && dma_done) begin
                    if (exp_slot_q.size() == 0) begin
                        check(1'b0, "R3 unexpected transfer", int'(dma_slot), -1);
                    end else begin
                        int es, eb;
                        es = exp_slot_q.pop_front();
                        eb = exp_buf_q.pop_front();
                        check(int'(dma_slot) == es, "R3/R4 slot order", int'(dma_slot), es);
                        check(int'(dma_buf) == eb, "R6 staging buffer", int'(dma_buf), eb);
                        check(in_clr_valid && int'(in_clr_slot) == es, "R5 clear pulse",
                              in_clr_valid ? int'(in_clr_slot) : -1, es);
                    end
                    in_done_cnt++;
                end else if (in_clr_valid) begin
                    check(1'b0, "R5 stray clear", int'(in_clr_slot), -1);
                end
                if (irq || irq_exp) check(irq == irq_exp, "R9 interrupt pulse", int'(irq), int'(irq_exp));
                irq_exp = out_set_valid;
                if (out_set_valid) begin
                    if (exp_out_q.size() == 0) begin
                        check(1'b0, "R9 unexpected set", int'(out_slot), -1);
                    end else begin
                        int eo;
                        eo = exp_out_q.pop_front();
                        check(int'(out_slot) == eo, "R9 set slot", int'(out_slot), eo);
                    end
                    out_done_cnt++;
                end
            end
        end
    end

    task automatic set_flags(input logic [NS-1:0] mask);
        @(posedge clk); #1 sw_set = mask;
        @(posedge clk); #1 sw_set = '0;
    endtask

    task automatic release_buf(input int b);
        @(posedge clk); #1 man_rel = 2'b01 << b;
        @(posedge clk); #1 man_rel = 2'b00;
    endtask

    task automatic push_in(input int s, input int b);
        exp_slot_q.push_back(s);
        exp_buf_q.push_back(b);
    endtask

    task automatic send_result(input int s);
        exp_out_q.push_back(s);
        @(posedge clk); #1;
        res_valid = 1'b1;
        res_slot  = SW'(s);
        do @(negedge clk); while (!res_ready);
        @(posedge clk); #1 res_valid = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", in_done_cnt, 0);
        finish_run();
    end

    // driver
    initial begin
        rst_n = 1'b0; sw_set = '0; sw_out_clr = '0; man_rel = 2'b00;
        res_valid = 1'b0; res_slot = '0; auto_rel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!dma_req, "R1 reset request", int'(dma_req), 0);
        check(!in_clr_valid, "R1 reset clear", int'(in_clr_valid), 0);
        check(!out_req && !res_ready, "R1 reset output", int'(out_req), 0);
        check(!irq, "R1 reset interrupt", int'(irq), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!dma_req && !irq, "R1 first cycle idle", int'(dma_req), 0);

        // ascending order, alternation, first buffer 0, sample latency
        push_in(2, 0); push_in(5, 1); push_in(9, 0);
        set_flags((NS'(1) << 2) | (NS'(1) << 5) | (NS'(1) << 9));
        @(negedge clk);
        @(negedge clk);
        check(!dma_req, "R2 no request one edge after snapshot", int'(dma_req), 0);
        @(negedge clk);
        check(dma_req && dma_slot == SW'(2), "R2 request two edges after flag", int'(dma_req), 1);
        wait (in_done_cnt == 2);
        repeat (6) @(negedge clk);
        check(!dma_req, "R6 stall with both buffers busy", int'(dma_req), 0);
        release_buf(0);
        wait (in_done_cnt == 3);
        // preferred buffer 1 still busy, buffer 0 freed
        release_buf(0);
        push_in(7, 0);
        set_flags(NS'(1) << 7);
        wait (in_done_cnt == 4);
        release_buf(0);
        release_buf(1);
        auto_rel = 1'b1;

        // late flag at lower index waits for the next snapshot
        push_in(10, 1); push_in(20, 0); push_in(3, 1);
        set_flags((NS'(1) << 10) | (NS'(1) << 20));
        wait (dma_req);
        set_flags(NS'(1) << 3);
        wait (in_done_cnt == 7);
        repeat (10) @(posedge clk);

        // boundary slots from an idle scan
        push_in(0, 0); push_in(NS - 1, 1);
        set_flags(NS'(1) | (NS'(1) << (NS - 1)));
        wait (in_done_cnt == 9);

        // output: empty slot
        send_result(4);
        wait (out_done_cnt == 1);
        @(negedge clk);
        check(out_flags[4] == 1'b1, "R9 output flag set", int'(out_flags[4]), 1);

        // output: slot already full, result must wait
        exp_out_q.push_back(4);
        @(posedge clk); #1 res_valid = 1'b1; res_slot = SW'(4);
        repeat (5) @(negedge clk);
        check(!res_ready, "R8 no accept while full", int'(res_ready), 0);
        check(!out_req, "R8 no write while full", int'(out_req), 0);
        @(posedge clk); #1 sw_out_clr = NS'(1) << 4;
        @(posedge clk); #1 sw_out_clr = '0;
        do @(negedge clk); while (!res_ready);
        @(posedge clk); #1 res_valid = 1'b0;
        @(negedge clk);
        check(out_req && out_slot == SW'(4), "R10 write follows accept", int'(out_slot), 4);
        wait (out_done_cnt == 2);

        // back-to-back results
        send_result(10);
        send_result(11);
        wait (out_done_cnt == 4);
        repeat (4) @(negedge clk);
        check(exp_slot_q.size() == 0, "R5 all transfers completed", exp_slot_q.size(), 0);
        check(exp_out_q.size() == 0, "R9 all writes completed", exp_out_q.size(), 0);
        check(in_flags == '0, "R5 all input flags cleared", int'(in_flags != '0), 0);
        finish_run();
    end

endmodule